// File: doc/BRIEF.md
# Issue-Width Core Fusion Controller

This controller owns the partitioning of four 2-issue VLIW core slices. The slices can run as separate cores or be fused into wider ones: two neighbouring slices form a 4-issue core, and all four form one 8-issue core. Software writes a configuration word that names a partitioning and a per-core enable mask. The controller rejects words it cannot honour. For a legal word it works out which running slices the change disturbs. It halts those slices and waits for each of them to report that it has stopped. It then switches the whole partitioning in one clock edge.

For every slice the controller drives four outputs: the index of the slice that leads its fused group, the issue-width code of that group, a clock enable, and a run signal. Fetch and branch steering use the leader index. The clock enable gates off slices whose core is not enabled. A busy flag covers the time between an accepted write and the switch, so that software can save core state before a merge or split. A one-cycle done pulse marks the switch, and a sticky error flag records rejected words.

Top module: `issue_fusion_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the active partitioning is 0 with all four enable bits set; every slice is clocked and running; busy, done and error are low.
- R2: The configuration word holds the partitioning in bits [1:0] and the per-core enable mask in bits [5:2]; bits [7:6] are reserved. For each slice the leader index and width code follow the active partitioning. Partitioning 0 gives leaders 0,1,2,3 with width code 0 (2-issue). Partitioning 1 gives leaders 0,0,2,3 with width codes 1,1,0,0 (code 1 = 4-issue). Partitioning 2 gives leaders 0,0,2,2 with width code 1. Partitioning 3 gives leader 0 for all slices with width code 2 (8-issue).
- R3: A slice's clock enable equals the enable-mask bit of its leader slice, and a slice's run output is never high while its clock enable is low.
- R4: A slice is disturbed by a write when it is currently clocked and its leader or width changes, or its clock would turn off. A legal write that disturbs no slice takes effect at the capturing edge. The new partitioning, mask and run = new clock enables show in the next cycle, with done high for exactly that one cycle.
- R5: A legal write that disturbs some slice leaves the active configuration unchanged and raises busy from the next cycle. One edge later, the run outputs of the disturbed slices drop while the other slices keep running.
- R6: A pending switch takes effect at the first edge at which every disturbed slice shows its halt acknowledge high and its run low. After that edge the new configuration is active, run equals the new clock enables, busy is low and done pulses.
- R7: A word is illegal when a reserved bit is set or when an enable bit is set for a slice that does not lead its group. An illegal word changes neither the active nor the pending configuration, and it sets the error flag, which stays high until reset.
- R8: A legal write that arrives while a switch is pending replaces it. Only the slices that the new word disturbs must then acknowledge, and slices halted for the old word stay halted until the switch.
- R9: While any disturbed slice has not acknowledged halt, the configuration does not change and busy stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W (8) | Configuration word |
| halt_ack | input | 4 | Per-slice report that the slice has stopped |
| slice_master | output | 8 | Per-slice leader index, 2 bits per slice, slice 0 in the low bits |
| slice_width | output | 8 | Per-slice width code, 2 bits per slice |
| slice_clk_en | output | 4 | Per-slice clock-gate enable |
| slice_run | output | 4 | Per-slice run (high) or halt (low) |
| act_mode | output | 2 | Active partitioning |
| act_en | output | 4 | Active enable mask |
| busy | output | 1 | A switch is waiting for halt acknowledges |
| done | output | 1 | One-cycle pulse after a switch |
| cfg_err | output | 1 | Sticky flag for rejected words |

## Verification
The bench starts from every legal configuration and writes every word with clear reserved bits, plus several words with reserved bits set. Each case exercises the bypass path, the halt-and-wait path and the rejection path against an arithmetic model of leaders, widths and disturbed slices. A design that ignores width changes would switch slice 0 of a merging pair without halting it. A design that counts unclocked slices as disturbed would hang waiting for an acknowledge that never comes. Partial acknowledges are used to catch a switch that fires too early. A replacement test checks that a second word drops the first word's acknowledge demands, and that a rejected word in flight disturbs neither the pending switch nor the halted slices.

// File: rtl/fusion_pkg.sv
`timescale 1ns/1ps
package fusion_pkg;
  localparam int NUM_SLICES = 4;
  localparam int IDX_W      = $clog2(NUM_SLICES);
  localparam int MODE_W     = 2;
  localparam int WID_W      = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_4X2     = 2'd0,
    MODE_1X4_2X2 = 2'd1,
    MODE_2X4     = 2'd2,
    MODE_1X8     = 2'd3
  } fuse_mode_e;

  typedef enum logic [WID_W-1:0] {
    ISSUE2 = 2'd0,
    ISSUE4 = 2'd1,
    ISSUE8 = 2'd2
  } issue_w_e;

  typedef logic [NUM_SLICES-1:0][IDX_W-1:0] master_map_t;
  typedef logic [NUM_SLICES-1:0][WID_W-1:0] width_map_t;

  // Leader slice of slice s under partitioning m (fusion only between neighbours).
  function automatic logic [IDX_W-1:0] lead_of(fuse_mode_e m, int unsigned s);
    logic [IDX_W-1:0] si;
    si = IDX_W'(s);
    case (m)
      MODE_4X2:     return si;
      MODE_1X4_2X2: return (s < 2) ? '0 : si;
      MODE_2X4:     return {si[IDX_W-1:1], 1'b0};
      default:      return '0;
    endcase
  endfunction

  function automatic issue_w_e width_of(fuse_mode_e m, int unsigned s);
    case (m)
      MODE_4X2:     return ISSUE2;
      MODE_1X4_2X2: return (s < 2) ? ISSUE4 : ISSUE2;
      MODE_2X4:     return ISSUE4;
      default:      return ISSUE8;
    endcase
  endfunction
endpackage

// File: rtl/fusion_decode.sv
`timescale 1ns/1ps
// Expands a partitioning and enable mask into per-slice leader, width and clock.
module fusion_decode
  import fusion_pkg::*;
(
  input  fuse_mode_e            mode,
  input  logic [NUM_SLICES-1:0] en_mask,
  output master_map_t           master,
  output width_map_t            width,
  output logic [NUM_SLICES-1:0] clk_en
);
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    assign master[s] = lead_of(mode, s);
    assign width[s]  = width_of(mode, s);
    assign clk_en[s] = en_mask[master[s]];
  end
endmodule

// File: rtl/fusion_impact.sv
`timescale 1ns/1ps
// Marks slices that are clocked now and would be disturbed by a new configuration.
module fusion_impact
  import fusion_pkg::*;
(
  input  master_map_t           old_master,
  input  width_map_t            old_width,
  input  logic [NUM_SLICES-1:0] old_clk,
  input  master_map_t           new_master,
  input  width_map_t            new_width,
  input  logic [NUM_SLICES-1:0] new_clk,
  output logic [NUM_SLICES-1:0] need
);
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    logic regroup;
    assign regroup = (old_master[s] != new_master[s]) ||
                     (old_width[s]  != new_width[s])  || !new_clk[s];
    assign need[s] = old_clk[s] && regroup;
  end
endmodule

// File: rtl/issue_fusion_ctrl.sv
`timescale 1ns/1ps
module issue_fusion_ctrl
  import fusion_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_W-1:0]              cfg_wdata,
  input  logic [NUM_SLICES-1:0]         halt_ack,
  output logic [NUM_SLICES*IDX_W-1:0]   slice_master,
  output logic [NUM_SLICES*WID_W-1:0]   slice_width,
  output logic [NUM_SLICES-1:0]         slice_clk_en,
  output logic [NUM_SLICES-1:0]         slice_run,
  output logic [MODE_W-1:0]             act_mode,
  output logic [NUM_SLICES-1:0]         act_en,
  output logic                          busy,
  output logic                          done,
  output logic                          cfg_err
);
  localparam int EN_LSB  = MODE_W;
  localparam int RSV_LSB = MODE_W + NUM_SLICES;

  // ---------------- state ----------------
  fuse_mode_e            act_mode_q, act_mode_d;
  logic [NUM_SLICES-1:0] act_en_q, act_en_d;
  logic                  act_ld;
  fuse_mode_e            pend_mode_q;
  logic [NUM_SLICES-1:0] pend_en_q;
  logic                  pend_ld;
  logic                  pend_q, pend_d;
  logic [NUM_SLICES-1:0] run_q, run_d;
  logic                  err_q, err_d;
  logic                  done_q, done_d;

  // ---------------- write decode ----------------
  fuse_mode_e            wr_mode;
  logic [NUM_SLICES-1:0] wr_en;
  logic                  wr_rsv_ok, wr_en_ok;
  logic [NUM_SLICES-1:0] wr_nonlead;

  assign wr_mode   = fuse_mode_e'(cfg_wdata[MODE_W-1:0]);
  assign wr_en     = cfg_wdata[RSV_LSB-1:EN_LSB];
  assign wr_rsv_ok = (cfg_wdata[CFG_W-1:RSV_LSB] == '0);

  master_map_t           act_master, wr_master, pend_master;
  width_map_t            act_width,  wr_width,  pend_width;
  logic [NUM_SLICES-1:0] act_clk,    wr_clk,    pend_clk;

  fusion_decode u_act_dec (
    .mode(act_mode_q), .en_mask(act_en_q),
    .master(act_master), .width(act_width), .clk_en(act_clk)
  );
  fusion_decode u_wr_dec (
    .mode(wr_mode), .en_mask(wr_en),
    .master(wr_master), .width(wr_width), .clk_en(wr_clk)
  );
  fusion_decode u_pend_dec (
    .mode(pend_mode_q), .en_mask(pend_en_q),
    .master(pend_master), .width(pend_width), .clk_en(pend_clk)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_lead
    assign wr_nonlead[s] = (wr_master[s] != IDX_W'(s));
  end
  assign wr_en_ok = ((wr_en & wr_nonlead) == '0);

  // ---------------- disturbed-slice masks ----------------
  logic [NUM_SLICES-1:0] wr_need, pend_need;

  fusion_impact u_wr_imp (
    .old_master(act_master), .old_width(act_width), .old_clk(act_clk),
    .new_master(wr_master),  .new_width(wr_width),  .new_clk(wr_clk),
    .need(wr_need)
  );
  fusion_impact u_pend_imp (
    .old_master(act_master),  .old_width(act_width),  .old_clk(act_clk),
    .new_master(pend_master), .new_width(pend_width), .new_clk(pend_clk),
    .need(pend_need)
  );

  // ---------------- control ----------------
  logic wr_legal, wr_bad, wr_direct, wr_hold, pend_ready, pend_fire;

  assign wr_legal   = cfg_we && wr_rsv_ok && wr_en_ok;
  assign wr_bad     = cfg_we && !(wr_rsv_ok && wr_en_ok);
  assign wr_direct  = wr_legal && (wr_need == '0);
  assign wr_hold    = wr_legal && (wr_need != '0);
  assign pend_ready = ((pend_need & halt_ack & ~run_q) == pend_need);
  assign pend_fire  = pend_q && pend_ready && !wr_legal;

  always_comb begin
    act_ld     = 1'b0;
    act_mode_d = act_mode_q;
    act_en_d   = act_en_q;
    pend_ld    = 1'b0;
    pend_d     = pend_q;
    run_d      = run_q;
    done_d     = 1'b0;
    err_d      = err_q | wr_bad;
    if (wr_direct) begin
      act_ld     = 1'b1;
      act_mode_d = wr_mode;
      act_en_d   = wr_en;
      pend_d     = 1'b0;
      run_d      = wr_clk;
      done_d     = 1'b1;
    end else if (wr_hold) begin
      pend_ld    = 1'b1;
      pend_d     = 1'b1;
    end else if (pend_fire) begin
      act_ld     = 1'b1;
      act_mode_d = pend_mode_q;
      act_en_d   = pend_en_q;
      pend_d     = 1'b0;
      run_d      = pend_clk;
      done_d     = 1'b1;
    end else if (pend_q) begin
      run_d      = run_q & ~pend_need;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode_q <= MODE_4X2;
      act_en_q   <= '1;
    end else if (act_ld) begin
      act_mode_q <= act_mode_d;
      act_en_q   <= act_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_mode_q <= MODE_4X2;
      pend_en_q   <= '0;
    end else if (pend_ld) begin
      pend_mode_q <= wr_mode;
      pend_en_q   <= wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      run_q  <= '1;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      run_q  <= run_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  // ---------------- outputs ----------------
  assign slice_master = act_master;
  assign slice_width  = act_width;
  assign slice_clk_en = act_clk;
  assign slice_run    = run_q;
  assign act_mode     = act_mode_q;
  assign act_en       = act_en_q;
  assign busy         = pend_q;
  assign done         = done_q;
  assign cfg_err      = err_q;
endmodule

// File: rtl/fusion_ctrl_chk.sv
`timescale 1ns/1ps
module fusion_ctrl_chk
  import fusion_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic [NUM_SLICES-1:0]       halt_ack,
  input logic [NUM_SLICES*IDX_W-1:0] slice_master,
  input logic [NUM_SLICES*WID_W-1:0] slice_width,
  input logic [NUM_SLICES-1:0]       slice_clk_en,
  input logic [NUM_SLICES-1:0]       slice_run,
  input logic [MODE_W-1:0]           act_mode,
  input logic [NUM_SLICES-1:0]       act_en,
  input logic                        busy,
  input logic                        done,
  input logic                        cfg_err
);
  // R3
  run_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_run & ~slice_clk_en) == '0);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_we));

  // R4
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode != $past(act_mode) || act_en != $past(act_en)) |-> done);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($stable(act_mode) && $stable(act_en)));

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    // R6
    halt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((slice_master[s*IDX_W +: IDX_W] != $past(slice_master[s*IDX_W +: IDX_W]) ||
        slice_width[s*WID_W +: WID_W]  != $past(slice_width[s*WID_W +: WID_W])) &&
       $past(slice_clk_en[s]))
      |-> (!$past(slice_run[s]) && $past(halt_ack[s])));

    // R2
    lead_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slice_master[s*IDX_W +: IDX_W] <= IDX_W'(s));
  end
endmodule

bind issue_fusion_ctrl fusion_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .halt_ack(halt_ack),
  .slice_master(slice_master), .slice_width(slice_width),
  .slice_clk_en(slice_clk_en), .slice_run(slice_run),
  .act_mode(act_mode), .act_en(act_en), .busy(busy), .done(done),
  .cfg_err(cfg_err)
);

// File: tb/tb_issue_fusion_ctrl.sv
`timescale 1ns/1ps
module tb_issue_fusion_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [3:0] halt_ack;
  logic [7:0] slice_master, slice_width;
  logic [3:0] slice_clk_en, slice_run, act_en;
  logic [1:0] act_mode;
  logic       busy, done, cfg_err;

  int vectors = 0;
  int fails   = 0;

  int         m_mode;
  logic [3:0] m_en;
  logic       m_err;

  always #2 clk = ~clk;

  issue_fusion_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .halt_ack(halt_ack), .slice_master(slice_master), .slice_width(slice_width),
    .slice_clk_en(slice_clk_en), .slice_run(slice_run), .act_mode(act_mode),
    .act_en(act_en), .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  // Expected leader / width per the R2 tables.
  function automatic int exp_lead(int m, int s);
    case (m)
      0:       return s;
      1:       return (s < 2) ? 0 : s;
      2:       return (s < 2) ? 0 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_wid(int m, int s);
    case (m)
      0:       return 0;
      1:       return (s < 2) ? 1 : 0;
      2:       return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [3:0] exp_clk(int m, logic [3:0] en);
    logic [3:0] c;
    for (int s = 0; s < 4; s++) c[s] = en[exp_lead(m, s)];
    return c;
  endfunction

  function automatic logic word_legal(logic [7:0] w);
    logic ok;
    ok = (w[7:6] == 2'b00);
    for (int s = 0; s < 4; s++)
      if (w[2+s] && exp_lead(int'(w[1:0]), s) != s) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [3:0] exp_need(int om, logic [3:0] oen, int nm, logic [3:0] nen);
    logic [3:0] n, oc, nc;
    oc = exp_clk(om, oen);
    nc = exp_clk(nm, nen);
    for (int s = 0; s < 4; s++)
      n[s] = oc[s] && (exp_lead(om, s) != exp_lead(nm, s) ||
                       exp_wid(om, s) != exp_wid(nm, s) || !nc[s]);
    return n;
  endfunction

  function automatic logic [32:0] exp_vec(int m, logic [3:0] en, logic [3:0] run,
                                          logic bz, logic dn, logic er);
    logic [7:0] mm, ww;
    for (int s = 0; s < 4; s++) begin
      mm[s*2 +: 2] = 2'(exp_lead(m, s));
      ww[s*2 +: 2] = 2'(exp_wid(m, s));
    end
    return {2'(m), en, mm, ww, exp_clk(m, en), run, bz, dn, er};
  endfunction

  task automatic chk(input logic [32:0] exp, input string req);
    logic [32:0] act;
    act = {act_mode, act_en, slice_master, slice_width, slice_clk_en,
           slice_run, busy, done, cfg_err};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; halt_ack = '0;
    repeat (2) @(negedge clk);
    chk(exp_vec(0, 4'hF, 4'hF, 0, 0, 0), "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    m_mode = 0; m_en = 4'hF; m_err = 1'b0;
    chk(exp_vec(0, 4'hF, 4'hF, 0, 0, 0), "R1 after release");
  endtask

  task automatic write_settle(input logic [7:0] w);
    logic       lg;
    logic [3:0] nd, oc, nen;
    int         nm;
    nm  = int'(w[1:0]);
    nen = w[5:2];
    lg  = word_legal(w);
    oc  = exp_clk(m_mode, m_en);
    nd  = lg ? exp_need(m_mode, m_en, nm, nen) : 4'h0;
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!lg) begin
      m_err = 1'b1;
      chk(exp_vec(m_mode, m_en, oc, 0, 0, 1), "R7 illegal ignored");
    end else if (nd == 4'h0) begin
      m_mode = nm; m_en = nen;
      chk(exp_vec(m_mode, m_en, exp_clk(nm, nen), 0, 1, m_err), "R2 R4 direct switch");
      @(negedge clk);
      chk(exp_vec(m_mode, m_en, exp_clk(nm, nen), 0, 0, m_err), "R4 done one cycle");
    end else begin
      chk(exp_vec(m_mode, m_en, oc, 1, 0, m_err), "R5 held pending");
      @(negedge clk);
      chk(exp_vec(m_mode, m_en, oc & ~nd, 1, 0, m_err), "R5 disturbed halted");
      if ($countones(nd) > 1) begin
        halt_ack = nd & (~nd + 4'd1);
        @(negedge clk);
        chk(exp_vec(m_mode, m_en, oc & ~nd, 1, 0, m_err), "R9 partial ack waits");
      end
      halt_ack = nd;
      @(negedge clk);
      halt_ack = 4'h0;
      m_mode = nm; m_en = nen;
      chk(exp_vec(m_mode, m_en, exp_clk(nm, nen), 0, 1, m_err), "R2 R6 switch after acks");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // Sweep: every legal start state x every word with clear reserved bits, plus reserved words.
    for (int f = 0; f < 64; f++) begin
      if (word_legal(8'(f))) begin
        for (int t = 0; t < 67; t++) begin
          logic [7:0] w;
          w = (t < 64) ? 8'(t) : (8'((t - 63) << 6) | 8'h04);
          do_reset();
          write_settle(8'(f));
          write_settle(w);
        end
      end
    end

    // R8: replacement of a pending switch, with an illegal word in between.
    do_reset();
    cfg_we = 1'b1; cfg_wdata = 8'h07;          // mode 3, enable slice 0: disturbs all four
    @(negedge clk);
    cfg_we = 1'b0;
    chk(exp_vec(0, 4'hF, 4'hF, 1, 0, 0), "R8 first word pending");
    @(negedge clk);
    chk(exp_vec(0, 4'hF, 4'h0, 1, 0, 0), "R8 all slices halted");
    cfg_we = 1'b1; cfg_wdata = 8'hC0;          // reserved bits set
    @(negedge clk);
    cfg_we = 1'b0;
    chk(exp_vec(0, 4'hF, 4'h0, 1, 0, 1), "R7 illegal during pending");
    cfg_we = 1'b1; cfg_wdata = 8'h35;          // mode 1, enables 3,2,0: disturbs slices 0,1
    @(negedge clk);
    cfg_we = 1'b0;
    chk(exp_vec(0, 4'hF, 4'h0, 1, 0, 1), "R8 replaced, still waiting");
    halt_ack = 4'b0011;
    @(negedge clk);
    halt_ack = 4'h0;
    chk(exp_vec(1, 4'hD, 4'hF, 0, 1, 1), "R8 switch on new acks only");
    @(negedge clk);
    chk(exp_vec(1, 4'hD, 4'hF, 0, 0, 1), "R7 error stays set");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule